// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block gathers up to 24 raw event signals from one functional module and turns them into interrupt requests for two independent host lines. Each raw input is synchronized and edge-detected. A trigger configuration shared by both lines decides which edges count: rising, falling, both or none. A counted edge is latched into the status bank of each line whose mask bit for that source is clear. Each line drives its own active-low interrupt output.

Software reaches the block through a byte-wide register port. Writes are single-cycle strobes and read data is combinational. A control register selects one of two acknowledgement styles. In the first, reading a status byte clears the bits it returned. In the second, writing ones clears the chosen bits. The same register can enable buffering of one extra event per source. A test-set register forces status bits so that the interrupt paths can be exercised without real events.

Top module: `evt_collect2`

## Requirements
- R1: After reset both interrupt outputs are high, every implemented mask bit reads 1, every trigger byte reads 0x00 and the control register reads 0x00.
- R2: Trigger byte k (at 0x0C+k) holds the fields of sources 4k..4k+3. Source i uses bits 2*(i mod 4)+1 (rising edge enable) and 2*(i mod 4) (falling edge enable). Value 2'b10 latches only on a 0-to-1 input change, 2'b01 only on a 1-to-0 change, and 2'b11 on both.
- R3: A source whose trigger field is 2'b00 never latches a status bit on either line, whatever its input does.
- R4: A set mask bit stops that source from latching on its own line only. The other line still latches the event when its own mask bit is clear.
- R5: irq_n[l] is low exactly while line l has a status bit set whose mask bit on that line is clear.
- R6: With control bit 0 set (clear-on-read), a read of a status byte returns the pending bits and clears them on that line only. Writes to status bytes are ignored.
- R7: With control bit 0 clear, reads leave status unchanged. Writing a status byte clears only the bits written as 1.
- R8: Status and mask bits at positions N and above read as 0, and test-set writes to them have no effect.
- R9: With control bit 1 set, an event that arrives while its status bit is already set is held. It sets the bit again one cycle after the bit is cleared. With control bit 1 clear, that event is lost.
- R10: A write to test-set byte k (at 0x13+k) sets the status bits of sources 8k..8k+7 written as 1 on both lines, regardless of mask and trigger. Test-set bytes read as 0x00.
- R11: The register map is as follows. Line-0 status is at 0x00-0x02 and line-0 mask at 0x03-0x05. Line-1 status is at 0x06-0x08 and line-1 mask at 0x09-0x0B. Trigger bytes are at 0x0C-0x11, control at 0x12 and test-set at 0x13-0x15. Within a status or mask byte k, bit b belongs to source 8k+b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_raw | input | NSRC | Raw event inputs, asynchronous |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (drives clear-on-read) |
| reg_rdata | output | 8 | Combinational read data |
| irq_n | output | 2 | Active-low interrupt, one per host line |

## Verification
The bench builds the block with NSRC set to 10. With that value the second status and mask bytes are only partly populated, so bits 10 to 15 must read zero. It also leaves part of the third trigger byte unused. Sources 8 and 9 sit in the second status byte, which tests the byte-to-source mapping beyond the first byte. The trigger table covers every two-bit encoding against both edge directions on both lines. Directed sequences cover the per-line masks, both acknowledgement modes and the buffered second event.

// File: rtl/evt_collect2_pkg.sv
package evt_collect2_pkg;

  localparam int unsigned MAX_SRC = 24;
  localparam int unsigned SB_MAX  = 3;
  localparam int unsigned TB_MAX  = 6;

  localparam logic [4:0] A_STAT0 = 5'h00;
  localparam logic [4:0] A_MASK0 = 5'h03;
  localparam logic [4:0] A_STAT1 = 5'h06;
  localparam logic [4:0] A_MASK1 = 5'h09;
  localparam logic [4:0] A_TRIG  = 5'h0C;
  localparam logic [4:0] A_CTRL  = 5'h12;
  localparam logic [4:0] A_TSET  = 5'h13;

  typedef struct packed {
    logic pend_en;
    logic clr_on_rd;
  } ctrl_t;

  function automatic int unsigned bytes_for(int unsigned nbits);
    return (nbits + 7) / 8;
  endfunction

  function automatic int unsigned rise_pos(int unsigned src);
    return 8 * (src / 4) + 2 * (src % 4) + 1;
  endfunction

  function automatic int unsigned fall_pos(int unsigned src);
    return 8 * (src / 4) + 2 * (src % 4);
  endfunction

  function automatic logic [4:0] stat_base(int unsigned line);
    return (line == 0) ? A_STAT0 : A_STAT1;
  endfunction

  function automatic logic [4:0] mask_base(int unsigned line);
    return (line == 0) ? A_MASK0 : A_MASK1;
  endfunction

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int unsigned NSRC   = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] fall_o
);

  logic [STAGES-1:0][NSRC-1:0] sync_q;
  logic [NSRC-1:0]             prev_q;
  logic [NSRC-1:0]             cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur    = sync_q[STAGES-1];
  assign rise_o = cur & ~prev_q;
  assign fall_o = ~cur & prev_q;

endmodule

// File: rtl/evt_line_bank.sv
module evt_line_bank #(
  parameter int unsigned NSRC = 24,
  parameter int unsigned SB   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit_i,
  input  logic [NSRC-1:0] tset_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            pend_en_i,
  input  logic [SB-1:0]   mask_we_i,
  input  logic [7:0]      wdata_i,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_n_o
);

  logic [NSRC-1:0] stat_q, mask_q, pend_q;
  logic [NSRC-1:0] latch_v, restore_v, stat_d, pend_d;

  assign latch_v   = (hit_i & ~mask_q) | tset_i;
  assign restore_v = pend_q & ~stat_q;
  assign stat_d    = (stat_q & ~clr_i) | latch_v | restore_v;
  assign pend_d    = (pend_q & ~restore_v) |
                     (latch_v & stat_q & ~clr_i & {NSRC{pend_en_i}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (mask_we_i[i/8]) mask_q[i] <= wdata_i[i%8];
    end
  end

  assign stat_o  = stat_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;
  assign irq_n_o = ~|(stat_q & ~mask_q);

endmodule

// File: rtl/evt_collect2.sv
module evt_collect2
  import evt_collect2_pkg::*;
#(
  parameter int unsigned NSRC        = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_raw,
  input  logic [4:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  input  logic            reg_rd,
  output logic [7:0]      reg_rdata,
  output logic [1:0]      irq_n
);

  localparam int unsigned SB    = bytes_for(NSRC);
  localparam int unsigned TB    = bytes_for(2 * NSRC);
  localparam int unsigned PADW  = 8 * SB_MAX;
  localparam int unsigned TPADW = 8 * TB_MAX;

  logic [NSRC-1:0]       rise_v, fall_v;
  logic [NSRC-1:0]       trig_rise, trig_fall, no_trig_v, edge_hit;
  logic [NSRC-1:0]       tset_v;
  logic [8*TB-1:0]       trig_q;
  ctrl_t                 ctrl_q;
  logic [1:0][NSRC-1:0]  stat_v, mask_v, pend_v;

  // named internal events for the checker
  logic [NSRC-1:0] line_stat0, line_stat1, line_mask0, line_mask1;
  logic [NSRC-1:0] line_pend0, line_pend1;

  evt_edge_det #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (evt_raw),
    .rise_o (rise_v),
    .fall_o (fall_v)
  );

  // shared trigger configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
    end else begin
      for (int k = 0; k < TB; k++)
        if (reg_wr && reg_addr == A_TRIG + 5'(k)) trig_q[8*k +: 8] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[1:0]);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign trig_rise[i] = trig_q[rise_pos(i)];
    assign trig_fall[i] = trig_q[fall_pos(i)];
    assign no_trig_v[i] = ~trig_rise[i] & ~trig_fall[i];
    assign edge_hit[i]  = (rise_v[i] & trig_rise[i]) | (fall_v[i] & trig_fall[i]);
    assign tset_v[i]    = reg_wr && (reg_addr == A_TSET + 5'(i/8)) && reg_wdata[i%8];
  end

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [NSRC-1:0] clr;
    logic [SB-1:0]   mask_we;

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
      logic in_byte;
      assign in_byte = (reg_addr == stat_base(l) + 5'(i/8));
      assign clr[i]  = ctrl_q.clr_on_rd ? (reg_rd && in_byte)
                                        : (reg_wr && in_byte && reg_wdata[i%8]);
    end

    for (genvar k = 0; k < SB; k++) begin : g_mwe
      assign mask_we[k] = reg_wr && (reg_addr == mask_base(l) + 5'(k));
    end

    evt_line_bank #(.NSRC(NSRC), .SB(SB)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (edge_hit),
      .tset_i    (tset_v),
      .clr_i     (clr),
      .pend_en_i (ctrl_q.pend_en),
      .mask_we_i (mask_we),
      .wdata_i   (reg_wdata),
      .stat_o    (stat_v[l]),
      .mask_o    (mask_v[l]),
      .pend_o    (pend_v[l]),
      .irq_n_o   (irq_n[l])
    );
  end

  assign line_stat0 = stat_v[0];
  assign line_stat1 = stat_v[1];
  assign line_mask0 = mask_v[0];
  assign line_mask1 = mask_v[1];
  assign line_pend0 = pend_v[0];
  assign line_pend1 = pend_v[1];

  // read mux
  logic [PADW-1:0]  s0p, s1p, m0p, m1p;
  logic [TPADW-1:0] tp;

  assign s0p = PADW'(line_stat0);
  assign s1p = PADW'(line_stat1);
  assign m0p = PADW'(line_mask0);
  assign m1p = PADW'(line_mask1);
  assign tp  = TPADW'(trig_q);

  always_comb begin
    reg_rdata = 8'h00;
    for (int k = 0; k < SB_MAX; k++) begin
      if (reg_addr == A_STAT0 + 5'(k)) reg_rdata = s0p[8*k +: 8];
      if (reg_addr == A_MASK0 + 5'(k)) reg_rdata = m0p[8*k +: 8];
      if (reg_addr == A_STAT1 + 5'(k)) reg_rdata = s1p[8*k +: 8];
      if (reg_addr == A_MASK1 + 5'(k)) reg_rdata = m1p[8*k +: 8];
    end
    for (int k = 0; k < TB_MAX; k++)
      if (reg_addr == A_TRIG + 5'(k)) reg_rdata = tp[8*k +: 8];
    if (reg_addr == A_CTRL) reg_rdata = {6'b0, ctrl_q};
  end

endmodule

// File: rtl/evt_collect2_chk.sv
module evt_collect2_chk
  import evt_collect2_pkg::*;
#(
  parameter int unsigned NSRC = 24,
  parameter int unsigned SB   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_rd,
  input logic [4:0]      reg_addr,
  input logic [7:0]      reg_rdata,
  input logic [1:0]      irq_n,
  input logic            cor,
  input logic [NSRC-1:0] stat0,
  input logic [NSRC-1:0] stat1,
  input logic [NSRC-1:0] mask0,
  input logic [NSRC-1:0] mask1,
  input logic [NSRC-1:0] pend0,
  input logic [NSRC-1:0] pend1,
  input logic [NSRC-1:0] rise_v,
  input logic [NSRC-1:0] fall_v,
  input logic [NSRC-1:0] no_trig_v,
  input logic [NSRC-1:0] tset_v
);

  localparam int unsigned PADW = 8 * SB_MAX;
  localparam int unsigned REM  = NSRC % 8;
  localparam logic [7:0]  HI_MASK = (REM == 0) ? 8'h00 : 8'(8'hFF << REM);

  logic [PADW-1:0] s0p, evp, tsp;
  assign s0p = PADW'(stat0);
  assign evp = PADW'(rise_v | fall_v);
  assign tsp = PADW'(tset_v);

  // R1
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask0 == '1 && mask1 == '1));

  // R3
  stat0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat0 & ~$past(stat0) &
               ~$past(((rise_v | fall_v) & ~no_trig_v & ~mask0) | tset_v | pend0)) == '0));

  // R4
  stat1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat1 & ~$past(stat1) &
               ~$past(((rise_v | fall_v) & ~no_trig_v & ~mask1) | tset_v | pend1)) == '0));

  // R5
  irq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat0 & ~mask0) != '0) |-> !irq_n[0]);

  // R6
  cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && cor && reg_addr == A_STAT0) |=>
      ((s0p[7:0] & $past(reg_rdata) & ~$past(evp[7:0]) & ~$past(tsp[7:0])) == 8'h00));

  // R8
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT0 + 5'(SB - 1)) |-> ((reg_rdata & HI_MASK) == 8'h00));

  // R9
  pend_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 & ~stat0) != '0) |=> ((stat0 & $past(pend0 & ~stat0)) == $past(pend0 & ~stat0)));

endmodule

bind evt_collect2 evt_collect2_chk #(.NSRC(NSRC), .SB(SB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_n     (irq_n),
  .cor       (ctrl_q.clr_on_rd),
  .stat0     (line_stat0),
  .stat1     (line_stat1),
  .mask0     (line_mask0),
  .mask1     (line_mask1),
  .pend0     (line_pend0),
  .pend1     (line_pend1),
  .rise_v    (rise_v),
  .fall_v    (fall_v),
  .no_trig_v (no_trig_v),
  .tset_v    (tset_v)
);

// File: tb/evt_collect2_test.sv
`timescale 1ns/1ps
module evt_collect2_test;

  localparam int unsigned N = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_raw = '0;
  logic [4:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic         reg_rd = 1'b0;
  logic [7:0]   reg_rdata;
  logic [1:0]   irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  evt_collect2 #(.NSRC(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_raw   (evt_raw),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n)
  );

  // entry: [8:5] source, [4:3] field {rise,fall}, [2] start level, [1] end level, [0] expected latch
  localparam logic [8:0] VEC [10] = '{
    {4'd0, 2'b10, 1'b0, 1'b1, 1'b1},
    {4'd1, 2'b10, 1'b1, 1'b0, 1'b0},
    {4'd2, 2'b01, 1'b1, 1'b0, 1'b1},
    {4'd3, 2'b01, 1'b0, 1'b1, 1'b0},
    {4'd5, 2'b11, 1'b0, 1'b1, 1'b1},
    {4'd6, 2'b11, 1'b1, 1'b0, 1'b1},
    {4'd9, 2'b00, 1'b0, 1'b1, 1'b0},
    {4'd8, 2'b00, 1'b1, 1'b0, 1'b0},
    {4'd7, 2'b10, 1'b0, 1'b1, 1'b1},
    {4'd9, 2'b01, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(5'h00, 8'hFF); wr(5'h01, 8'hFF); wr(5'h06, 8'hFF); wr(5'h07, 8'hFF);
  endtask

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 irq_n", {6'b0, irq_n}, 8'h03);
    rd(5'h03, d); check("R1 mask0 byte0", d, 8'hFF);
    rd(5'h0A, d); check("R1 mask1 byte1", d, 8'h03);
    rd(5'h0C, d); check("R1 trig byte0", d, 8'h00);
    rd(5'h12, d); check("R1 ctrl", d, 8'h00);
    rd(5'h00, d); check("R1 stat0", d, 8'h00);
    // R8 mask bits above N
    rd(5'h04, d); check("R8 mask0 byte1 top bits", d, 8'h03);

    // unmask everything on both lines (R11 addresses)
    wr(5'h03, 8'h00); wr(5'h04, 8'h00); wr(5'h09, 8'h00); wr(5'h0A, 8'h00);

    // R2 / R3 trigger table
    for (int e = 0; e < 10; e++) begin
      int src;
      logic [1:0] fld;
      src = int'(VEC[e][8:5]);
      fld = VEC[e][4:3];
      wr(5'h0C, 8'h00); wr(5'h0D, 8'h00); wr(5'h0E, 8'h00);
      evt_raw[src] = VEC[e][2];
      idle(6);
      wr(5'h0C + 5'(src/4), 8'(fld) << (2*(src%4)));
      clear_all();
      evt_raw[src] = VEC[e][1];
      idle(6);
      rd(5'h00 + 5'(src/8), d);
      check((fld == 2'b00) ? "R3 line0" : "R2 line0", {7'b0, d[src%8]}, {7'b0, VEC[e][0]});
      rd(5'h06 + 5'(src/8), d);
      check((fld == 2'b00) ? "R3 line1" : "R2 line1", {7'b0, d[src%8]}, {7'b0, VEC[e][0]});
    end
    wr(5'h0C, 8'h00); wr(5'h0D, 8'h00); wr(5'h0E, 8'h00);
    evt_raw = '0;
    idle(6);
    clear_all();

    // R4 / R5 per-line mask
    wr(5'h0C, 8'h02);
    wr(5'h09, 8'h01);
    evt_raw[0] = 1'b1;
    idle(6);
    rd(5'h00, d); check("R4 line0 latched", d, 8'h01);
    rd(5'h06, d); check("R4 line1 masked", d, 8'h00);
    check("R5 irq line0 only", {6'b0, irq_n}, 8'h02);
    wr(5'h00, 8'h01);
    idle(1);
    check("R5 irq released", {6'b0, irq_n}, 8'h03);

    // R5 / R10 test-set with masked line
    wr(5'h03, 8'hFF);
    wr(5'h13, 8'h02);
    idle(1);
    check("R5 masked status no irq", {6'b0, irq_n}, 8'h01);
    rd(5'h00, d); check("R10 forced despite mask", d, 8'h02);
    rd(5'h06, d); check("R10 forced on line1", d, 8'h02);
    rd(5'h13, d); check("R10 test-set reads zero", d, 8'h00);
    wr(5'h03, 8'h00);
    idle(1);
    check("R5 unmask asserts irq", {6'b0, irq_n}, 8'h00);
    clear_all();

    // R7 clear-on-write
    wr(5'h13, 8'h06);
    wr(5'h00, 8'h02);
    rd(5'h00, d); check("R7 write-1 clears", d, 8'h04);
    rd(5'h00, d); check("R7 read does not clear", d, 8'h04);
    wr(5'h00, 8'h00);
    rd(5'h00, d); check("R7 write-0 no effect", d, 8'h04);
    rd(5'h06, d); check("R7 other line untouched", d, 8'h06);
    clear_all();

    // R6 clear-on-read
    wr(5'h12, 8'h01);
    wr(5'h13, 8'h08);
    rd(5'h00, d); check("R6 read returns", d, 8'h08);
    rd(5'h00, d); check("R6 read cleared", d, 8'h00);
    wr(5'h06, 8'hFF);
    rd(5'h06, d); check("R6 write ignored, line1 kept", d, 8'h08);
    rd(5'h06, d); check("R6 line1 cleared", d, 8'h00);

    // R8 bits above N
    wr(5'h14, 8'hFF);
    rd(5'h01, d); check("R8 top status bits zero", d, 8'h03);
    rd(5'h02, d); check("R8 absent byte zero", d, 8'h00);
    rd(5'h07, d);

    // R9 pending buffer enabled
    wr(5'h12, 8'h03);
    evt_raw[0] = 1'b0; idle(6);
    rd(5'h00, d);
    evt_raw[0] = 1'b1; idle(6);
    evt_raw[0] = 1'b0; idle(6);
    evt_raw[0] = 1'b1; idle(6);
    rd(5'h00, d); check("R9 first event", d, 8'h01);
    idle(3);
    rd(5'h00, d); check("R9 buffered event reasserts", d, 8'h01);
    rd(5'h00, d); check("R9 buffer consumed", d, 8'h00);

    // R9 pending buffer disabled
    wr(5'h12, 8'h01);
    evt_raw[0] = 1'b0; idle(6);
    evt_raw[0] = 1'b1; idle(6);
    evt_raw[0] = 1'b0; idle(6);
    evt_raw[0] = 1'b1; idle(6);
    rd(5'h00, d); check("R9 first event no buffer", d, 8'h01);
    idle(3);
    rd(5'h00, d); check("R9 second event lost", d, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule